// File: doc/BRIEF.md
# Bus Dominant Timeout Monitor

This block watches the received level of a single-wire, open-drain serial bus and measures how long the bus stays dominant (low) without a break. A dominant level can come from the local transmitter or from another node on the bus, and both are treated the same way. When the dominant run lasts longer than a set number of clock ticks, the block enters a protective trip state. In that state it blocks the local transmitter, overrides the receive data output to recessive, disconnects the bus pull-up to battery and raises a fault flag for the mode controller.

The trip state has no timer-based exit. It ends only when the bus returns to recessive or when the device is in its power-on reset mode. A recessive level clears the trip whether it comes from an external pull-up or from the local transmit data going high again. The input bus level must already be synchronized to `clk`: 1 means recessive and 0 means dominant. The limit is the parameter `LIMIT_CYCLES`. Its default is 2,500,000 ticks, which is about 20 ms at 125 MHz.

The controller has three states:

- `ST_IDLE`: the bus is recessive.
- `ST_TIMING`: the bus is dominant and the run is being counted.
- `ST_TRIPPED`: the protective shutdown is active.

It has these transitions:

- **start**: `ST_IDLE` to `ST_TIMING` on a dominant sample.
- **release**: `ST_TIMING` to `ST_IDLE` on a recessive sample.
- **expire**: `ST_TIMING` to `ST_TRIPPED` on a dominant sample once the counter has reached the limit.
- **recover**: `ST_TRIPPED` to `ST_IDLE` on a recessive sample.
- **por clear**: any state to `ST_IDLE` while the reset mode is active.

Top module: `bus_dom_guard`

## Requirements
- R1: The four protective outputs rise after the clock edge that samples the (LIMIT_CYCLES+1)-th consecutive dominant level (`bus_level_i` = 0).
- R2: A dominant run of LIMIT_CYCLES samples or fewer never trips the block. This includes a run one tick shorter than the limit.
- R3: While tripped, `tx_disable_o`, `rx_force_rec_o`, `pullup_off_o` and `fault_o` are all 1. When not tripped, all four are 0.
- R4: Once tripped, the block stays tripped for as long as the bus stays dominant and `por_mode_i` stays 0.
- R5: A recessive sample (`bus_level_i` = 1) clears the trip state after that edge. It also restarts the count, so a following dominant run is measured from zero.
- R6: `por_mode_i` = 1 clears the count and the trip state, even while the bus is dominant. No trip can occur while it is held.
- R7: The run counter saturates at the limit. A dominant run many times longer than the limit keeps the block tripped, with no wrap-around that would release it.
- R8: An asynchronous low on `rst_n` returns all outputs to 0 at once.
- R9: Dominant runs shorter than the limit, each separated by a single recessive sample, never add up to a trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_level_i | input | 1 | Synchronized received bus level, 1 = recessive, 0 = dominant |
| por_mode_i | input | 1 | High while the device is in power-on reset mode |
| tx_disable_o | output | 1 | Blocks the bus transmitter |
| rx_force_rec_o | output | 1 | Forces the receive data output recessive |
| pullup_off_o | output | 1 | Disconnects the bus pull-up to battery |
| fault_o | output | 1 | Fault indication to the mode controller |

## Verification
Every result is due one edge after the sample that causes it, because the outputs decode the state register directly. The trip rises one edge after the (LIMIT_CYCLES+1)-th dominant sample, and a clear lands on the edge after the recessive or reset-mode sample. The bench drives its inputs on the falling edge and steps a behavioural run-length model after each rising edge. It then compares all four outputs to the model on the next falling edge. The runs of exactly LIMIT_CYCLES-1, LIMIT_CYCLES and LIMIT_CYCLES+1 dominant samples pin the boundary to the exact cycle.

// File: rtl/bus_dom_guard_pkg.sv
package bus_dom_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_TRIPPED = 2'd2
    } guard_state_t;

endpackage

// File: rtl/dom_run_timer.sv
module dom_run_timer #(
    parameter int unsigned LIMIT_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rec,
    input  logic por_mode,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LIMIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bus_rec || por_mode) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expired = (cnt_q == CNT_MAX);

    // R7: the counter holds at the limit during a long dominant run
    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !bus_rec && !por_mode) |=> expired);

    // R5 / R6: a recessive sample or reset mode empties the counter
    assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rec || por_mode) |=> (cnt_q == '0));

endmodule

// File: rtl/dom_guard_fsm.sv
module dom_guard_fsm
    import bus_dom_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rec,
    input  logic por_mode,
    input  logic expired,
    output logic tx_disable,
    output logic rx_force_rec,
    output logic pullup_off,
    output logic fault
);
    guard_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (por_mode || bus_rec) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_TIMING;
                ST_TIMING:  state_d = expired ? ST_TRIPPED : ST_TIMING;
                ST_TRIPPED: state_d = ST_TRIPPED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tx_disable   = 1'b0;
        rx_force_rec = 1'b0;
        pullup_off   = 1'b0;
        fault        = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_TIMING: ;
            ST_TRIPPED: begin
                tx_disable   = 1'b1;
                rx_force_rec = 1'b1;
                pullup_off   = 1'b1;
                fault        = 1'b1;
            end
            default: ;
        endcase
    end

    // R1: a trip is only entered after the timer has expired
    assert_trip_after_expiry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(expired));

    // R4: the trip holds while the bus stays dominant outside reset mode
    assert_trip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !bus_rec && !por_mode) |=> fault);

    // R5: a recessive sample releases the shutdown
    assert_recessive_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rec |=> !tx_disable);

    // R6: reset mode forces the idle state
    assert_por_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        por_mode |=> (state_q == ST_IDLE));

endmodule

// File: rtl/bus_dom_guard.sv
module bus_dom_guard #(
    parameter int unsigned LIMIT_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_level_i,
    input  logic por_mode_i,
    output logic tx_disable_o,
    output logic rx_force_rec_o,
    output logic pullup_off_o,
    output logic fault_o
);
    logic expired;

    dom_run_timer #(.LIMIT_CYCLES(LIMIT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rec  (bus_level_i),
        .por_mode (por_mode_i),
        .expired  (expired)
    );

    dom_guard_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_rec      (bus_level_i),
        .por_mode     (por_mode_i),
        .expired      (expired),
        .tx_disable   (tx_disable_o),
        .rx_force_rec (rx_force_rec_o),
        .pullup_off   (pullup_off_o),
        .fault        (fault_o)
    );

    // R1 / R3: an expired timer with the bus still dominant shuts the driver off
    assert_expire_trips_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !bus_level_i && !por_mode_i) |=> (tx_disable_o && pullup_off_o));

    // R3: the protective outputs always move together
    assert_outputs_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_disable_o == fault_o) && (rx_force_rec_o == fault_o) && (pullup_off_o == fault_o));

endmodule

// File: tb/bus_dom_guard_test.sv
module bus_dom_guard_test;
    localparam int LIMIT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_level = 1'b1;
    logic por_mode = 1'b0;
    logic tx_dis, rx_rec, pu_off, flt;

    int n_tests = 0;
    int n_fail = 0;
    int run_len = 0;
    bit trip_exp = 1'b0;

    always #4 clk = ~clk;

    bus_dom_guard #(.LIMIT_CYCLES(LIMIT)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_level_i    (bus_level),
        .por_mode_i     (por_mode),
        .tx_disable_o   (tx_dis),
        .rx_force_rec_o (rx_rec),
        .pullup_off_o   (pu_off),
        .fault_o        (flt)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b, expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive inputs for n cycles, step the model each edge, compare on the falling edge
    task automatic run(input logic lvl, input logic por, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            bus_level = lvl;
            por_mode  = por;
            @(posedge clk);
            if (por || lvl) begin
                run_len  = 0;
                trip_exp = 1'b0;
            end else begin
                run_len++;
                if (run_len > LIMIT) trip_exp = 1'b1;
            end
            @(negedge clk);
            check(tag, {tx_dis, rx_rec, pu_off, flt}, {4{trip_exp}});
        end
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", {tx_dis, rx_rec, pu_off, flt}, 4'b0000);
        rst_n = 1'b1;
        run(1'b1, 1'b0, 5, "R5 idle");
        run(1'b0, 1'b0, LIMIT - 1, "R2 limit-1");
        run(1'b1, 1'b0, 2, "R2 release");
        run(1'b0, 1'b0, LIMIT, "R2 exact limit");
        run(1'b1, 1'b0, 2, "R2 release");
        run(1'b0, 1'b0, LIMIT + 1, "R1 trip");
        check("R1 trip edge", {tx_dis, rx_rec, pu_off, flt}, 4'b1111);
        run(1'b0, 1'b0, 10, "R3 R4 hold");
        run(1'b1, 1'b0, 1, "R5 recover");
        check("R5 cleared", {tx_dis, rx_rec, pu_off, flt}, 4'b0000);
        run(1'b0, 1'b0, LIMIT, "R5 restart");
        run(1'b0, 1'b0, 1, "R5 retrip");
        run(1'b0, 1'b0, 5 * LIMIT, "R7 saturate");
        run(1'b0, 1'b1, 5, "R6 por clear");
        run(1'b0, 1'b0, LIMIT + 1, "R6 trip after por");
        run(1'b1, 1'b0, 1, "R5 recover");
        run(1'b0, 1'b1, 3 * LIMIT, "R6 por held");
        run(1'b1, 1'b0, 1, "R9 gap");
        for (int k = 0; k < 6; k++) begin
            run(1'b0, 1'b0, LIMIT - 5, "R9 short run");
            run(1'b1, 1'b0, 1, "R9 gap");
        end
        run(1'b0, 1'b0, LIMIT + 3, "R1 trip again");
        #2;
        rst_n = 1'b0;
        #1;
        check("R8 async reset", {tx_dis, rx_rec, pu_off, flt}, 4'b0000);
        run_len = 0;
        trip_exp = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run(1'b0, 1'b0, LIMIT - 1, "R8 R2 after reset");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule